// File: doc/BRIEF.md
# Indexed Chipset Configuration Unit with SMRAM Window Decode

This block is a legacy chipset configuration unit. Software reaches it through two I/O ports. A byte written to the index port picks one of 256 byte-wide configuration registers. A later read or write on the data port then accesses that register. Writes to the data port change a register only while the key register holds its unlock value. The one exception is the key register itself, which can always be written.

The main job of the block is to decode a system-management RAM window. It works from the SMM control byte. A two-bit mode field picks one of three fixed host ranges, each with its own DRAM target. One of these moves a low host range onto the A0000h DRAM area. A visibility bit decides whether normal cycles also see the window, or only cycles made in system-management mode. For each host access the block gives a hit flag and the translated DRAM address in the same cycle.

Two side functions share the register path. Writing the SMI status register raises an SMI request. The request is held until a later write clears it. A dummy PCI status byte clears, on a write, each bit written as one, apart from its lowest bit.

Top module: `cfg_smram_unit`

## Requirements
- R1: A write to I/O address 22h loads the index. A read at 22h returns the index. A read at 23h returns the register the index selects. Any other I/O address reads as 00h.
- R2: After reset the index is 00h, all 256 registers are 00h, the SMI request is low and the PCI status byte equals its reset parameter (default 23h).
- R3: A data-port write to any register other than 03h takes effect only while register 03h holds C5h. A write to register 03h always takes effect.
- R4: When bits [5:4] of register 19h are 0, no host access hits, whatever its address or mode.
- R5: With bits [5:4] = 1, host addresses A0000h to BFFFFh hit and map to the same DRAM address.
- R6: With bits [5:4] = 2, host addresses E0000h to EFFFFh hit and map to the same DRAM address.
- R7: With bits [5:4] = 3, host addresses 30000h to 4FFFFh hit and map to DRAM address A0000h plus the offset from 30000h.
- R8: A hit needs the access strobe high. When bit 3 of register 19h is set, the window is visible to both SMM and normal accesses. When bit 3 is clear, only accesses with the SMM flag high can hit.
- R9: The translated DRAM address output is zero whenever there is no hit.
- R10: An accepted write to register 35h with bit 5 or bit 4 set raises the SMI request on the next cycle. The request stays high until an accepted write to 35h with both bits clear, or until reset.
- R11: A PCI configuration write to offset 07h clears each status bit written as 1, except bit 0, which a write never clears. PCI writes to any other offset leave the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_wr_i | input | 1 | I/O write strobe |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data for the current address |
| pci_wr_i | input | 1 | Dummy PCI configuration write strobe |
| pci_addr_i | input | 8 | PCI configuration byte offset |
| pci_wdata_i | input | 8 | PCI configuration write data |
| pci_status_o | output | 8 | Dummy PCI status byte |
| host_addr_i | input | 20 | Host memory address |
| host_smm_i | input | 1 | CPU is in system-management mode |
| host_strobe_i | input | 1 | Host access valid |
| smram_hit_o | output | 1 | Access falls in the active SMRAM window |
| dram_addr_o | output | 20 | Translated DRAM address, zero when there is no hit |
| smi_req_o | output | 1 | SMI request |

## Verification
The window decode is tried in every mode. In each mode the bench probes the addresses just below, at the bottom of, at the top of, and just above every candidate range. This shows whether the decoder picked the right base and size, and whether the relocated mode adds the right DRAM offset. Each probe is repeated with the SMM flag and the strobe each high and low, under both settings of the visibility bit. This separates SMM-private windows from open ones. Control writes are also made while the block is locked, which shows that the unlock gate blocks them. A reference model tracks the registers, the SMI request and the status byte, and checks every output on every clock.

// File: rtl/cfg_smram_pkg.sv
package cfg_smram_pkg;

  typedef enum logic [1:0] {
    SMW_OFF   = 2'd0,
    SMW_LOW   = 2'd1,
    SMW_HIGH  = 2'd2,
    SMW_RELOC = 2'd3
  } smw_mode_e;

  localparam logic [7:0] UNLOCK_KEY     = 8'hC5;
  localparam logic [7:0] REG_KEY        = 8'h03;
  localparam logic [7:0] REG_SMM_CTRL   = 8'h19;
  localparam logic [7:0] REG_SMI_STAT   = 8'h35;
  localparam logic [7:0] PCI_STATUS_OFS = 8'h07;

  function automatic logic [31:0] win_host_base(input logic [1:0] m);
    case (m)
      2'd1:    return 32'h000A_0000;
      2'd2:    return 32'h000E_0000;
      2'd3:    return 32'h0003_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] win_dram_base(input logic [1:0] m);
    case (m)
      2'd1:    return 32'h000A_0000;
      2'd2:    return 32'h000E_0000;
      2'd3:    return 32'h000A_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] win_size(input logic [1:0] m);
    case (m)
      2'd1:    return 32'h0002_0000;
      2'd2:    return 32'h0001_0000;
      2'd3:    return 32'h0002_0000;
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_smram_pkg::*;
#(
  parameter int          NREG      = 256,
  parameter int          IO_AW     = 16,
  parameter logic [15:0] IDX_PORT  = 16'h0022,
  parameter logic [15:0] DATA_PORT = 16'h0023,
  localparam int         IDX_W     = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             io_wr_i,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic [7:0]       io_wdata_i,
  output logic [7:0]       io_rdata_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             unlocked_o,
  output logic             wr_accept_o,
  output logic [7:0]       smm_ctrl_o
);

  localparam logic [IDX_W-1:0] KEY_IDX = IDX_W'(REG_KEY);
  localparam logic [IDX_W-1:0] SMM_IDX = IDX_W'(REG_SMM_CTRL);

  logic [IDX_W-1:0] idx_q;
  logic [7:0]       regs_q [NREG];
  logic             sel_idx, sel_data;

  assign sel_idx     = (io_addr_i == IO_AW'(IDX_PORT));
  assign sel_data    = (io_addr_i == IO_AW'(DATA_PORT));
  assign unlocked_o  = (regs_q[KEY_IDX] == UNLOCK_KEY);
  // key register stays writable so a locked block can be opened
  assign wr_accept_o = io_wr_i && sel_data && (unlocked_o || idx_q == KEY_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (io_wr_i && sel_idx) begin
      idx_q <= IDX_W'(io_wdata_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_accept_o) begin
      regs_q[idx_q] <= io_wdata_i;
    end
  end

  always_comb begin
    io_rdata_o = '0;
    if (sel_idx)       io_rdata_o = 8'(idx_q);
    else if (sel_data) io_rdata_o = regs_q[idx_q];
  end

  assign idx_o      = idx_q;
  assign smm_ctrl_o = regs_q[SMM_IDX];

endmodule

// File: rtl/smram_window.sv
module smram_window
  import cfg_smram_pkg::*;
#(
  parameter int HOST_AW = 20
) (
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic               host_smm_i,
  input  logic               host_strobe_i,
  input  logic [7:0]         smm_ctrl_i,
  output smw_mode_e          mode_o,
  output logic               open_o,
  output logic               hit_o,
  output logic [HOST_AW-1:0] dram_addr_o
);

  logic [31:0]        addr32;
  logic [3:0]         in_win;
  logic [HOST_AW-1:0] xlat [4];

  assign addr32    = 32'(host_addr_i);
  assign mode_o    = smw_mode_e'(smm_ctrl_i[5:4]);
  assign open_o    = smm_ctrl_i[3];
  assign in_win[0] = 1'b0;
  assign xlat[0]   = '0;

  generate
    for (genvar m = 1; m < 4; m++) begin : g_win
      localparam logic [31:0] HB = win_host_base(2'(m));
      localparam logic [31:0] DB = win_dram_base(2'(m));
      localparam logic [31:0] SZ = win_size(2'(m));
      assign in_win[m] = (addr32 >= HB) && (addr32 < HB + SZ);
      assign xlat[m]   = HOST_AW'(addr32 - HB + DB);
    end
  endgenerate

  assign hit_o       = host_strobe_i && (mode_o != SMW_OFF) && in_win[mode_o]
                       && (host_smm_i || open_o);
  assign dram_addr_o = hit_o ? xlat[mode_o] : '0;

endmodule

// File: rtl/smi_ctrl.sv
module smi_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stat_wr_i,
  input  logic [7:0] stat_wdata_i,
  output logic       smi_req_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        smi_req_o <= 1'b0;
    else if (stat_wr_i) smi_req_o <= |stat_wdata_i[5:4];
  end

endmodule

// File: rtl/pci_status_w1c.sv
module pci_status_w1c
  import cfg_smram_pkg::*;
#(
  parameter logic [7:0] STATUS_INIT = 8'h23
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pci_wr_i,
  input  logic [7:0] pci_addr_i,
  input  logic [7:0] pci_wdata_i,
  output logic [7:0] status_o
);

  localparam logic [7:0] CLR_MASK = 8'hFE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= STATUS_INIT;
    end else if (pci_wr_i && pci_addr_i == PCI_STATUS_OFS) begin
      status_o <= status_o & ~(pci_wdata_i & CLR_MASK);
    end
  end

endmodule

// File: rtl/cfg_smram_unit.sv
module cfg_smram_unit
  import cfg_smram_pkg::*;
#(
  parameter int          HOST_AW     = 20,
  parameter int          IO_AW       = 16,
  parameter int          NREG        = 256,
  parameter logic [15:0] IDX_PORT    = 16'h0022,
  parameter logic [15:0] DATA_PORT   = 16'h0023,
  parameter logic [7:0]  STATUS_INIT = 8'h23,
  localparam int         IDX_W       = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               io_wr_i,
  input  logic [IO_AW-1:0]   io_addr_i,
  input  logic [7:0]         io_wdata_i,
  output logic [7:0]         io_rdata_o,
  input  logic               pci_wr_i,
  input  logic [7:0]         pci_addr_i,
  input  logic [7:0]         pci_wdata_i,
  output logic [7:0]         pci_status_o,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic               host_smm_i,
  input  logic               host_strobe_i,
  output logic               smram_hit_o,
  output logic [HOST_AW-1:0] dram_addr_o,
  output logic               smi_req_o
);

  logic [IDX_W-1:0] idx_q;
  logic             cfg_unlocked;
  logic             wr_accept;
  logic [7:0]       smm_ctrl;
  smw_mode_e        smm_mode;
  logic             smm_open;
  logic             smi_stat_wr;

  cfg_regfile #(
    .NREG(NREG), .IO_AW(IO_AW), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .io_wr_i     (io_wr_i),
    .io_addr_i   (io_addr_i),
    .io_wdata_i  (io_wdata_i),
    .io_rdata_o  (io_rdata_o),
    .idx_o       (idx_q),
    .unlocked_o  (cfg_unlocked),
    .wr_accept_o (wr_accept),
    .smm_ctrl_o  (smm_ctrl)
  );

  smram_window #(.HOST_AW(HOST_AW)) u_win (
    .host_addr_i   (host_addr_i),
    .host_smm_i    (host_smm_i),
    .host_strobe_i (host_strobe_i),
    .smm_ctrl_i    (smm_ctrl),
    .mode_o        (smm_mode),
    .open_o        (smm_open),
    .hit_o         (smram_hit_o),
    .dram_addr_o   (dram_addr_o)
  );

  assign smi_stat_wr = wr_accept && (idx_q == IDX_W'(REG_SMI_STAT));

  smi_ctrl u_smi (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stat_wr_i    (smi_stat_wr),
    .stat_wdata_i (io_wdata_i),
    .smi_req_o    (smi_req_o)
  );

  pci_status_w1c #(.STATUS_INIT(STATUS_INIT)) u_pci (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pci_wr_i    (pci_wr_i),
    .pci_addr_i  (pci_addr_i),
    .pci_wdata_i (pci_wdata_i),
    .status_o    (pci_status_o)
  );

endmodule

// File: rtl/cfg_smram_unit_chk.sv
module cfg_smram_unit_chk
  import cfg_smram_pkg::*;
#(
  parameter int HOST_AW = 20,
  parameter int IO_AW   = 16,
  parameter int IDX_W   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               io_wr_i,
  input logic [IO_AW-1:0]   io_addr_i,
  input logic [7:0]         io_wdata_i,
  input logic               pci_wr_i,
  input logic [7:0]         pci_status_o,
  input logic               host_smm_i,
  input logic               host_strobe_i,
  input logic               smram_hit_o,
  input logic [HOST_AW-1:0] dram_addr_o,
  input logic               smi_req_o,
  input logic [IDX_W-1:0]   idx_q,
  input logic               cfg_unlocked,
  input smw_mode_e          smm_mode,
  input logic               smm_open
);

  p_mode_off_no_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smm_mode == SMW_OFF) |-> !smram_hit_o);

  p_hit_needs_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_strobe_i |-> !smram_hit_o);

  p_private_window_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smram_hit_o && !host_smm_i) |-> smm_open);

  p_dram_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smram_hit_o |-> (dram_addr_o == '0));

  p_smi_raise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i == IO_AW'(16'h0023) && idx_q == IDX_W'(REG_SMI_STAT)
     && cfg_unlocked && (|io_wdata_i[5:4])) |=> smi_req_o);

  p_smi_locked_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_unlocked && idx_q != IDX_W'(REG_KEY)) |=> $stable(smi_req_o));

  p_status_bit0_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_wr_i |=> (pci_status_o[0] == $past(pci_status_o[0])));

endmodule

bind cfg_smram_unit cfg_smram_unit_chk #(
  .HOST_AW(HOST_AW), .IO_AW(IO_AW), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/cfg_smram_unit_bench.sv
`timescale 1ns/1ps
module cfg_smram_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata;
  logic        pci_wr = 1'b0;
  logic [7:0]  pci_addr = 8'h0;
  logic [7:0]  pci_wdata = 8'h0;
  logic [7:0]  pci_status;
  logic [19:0] host_addr = 20'h0;
  logic        host_smm = 1'b0;
  logic        host_strobe = 1'b0;
  logic        hit;
  logic [19:0] dram_addr;
  logic        smi_req;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [7:0] m_regs [256];
  logic [7:0] m_idx;
  logic       m_smi;
  logic [7:0] m_status;

  always #2.5 clk = ~clk;

  cfg_smram_unit u_cfg_smram_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .io_wr_i(io_wr), .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .pci_wr_i(pci_wr), .pci_addr_i(pci_addr), .pci_wdata_i(pci_wdata), .pci_status_o(pci_status),
    .host_addr_i(host_addr), .host_smm_i(host_smm), .host_strobe_i(host_strobe),
    .smram_hit_o(hit), .dram_addr_o(dram_addr), .smi_req_o(smi_req)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_regs[i] = 8'h0;
      m_idx = 8'h0; m_smi = 1'b0; m_status = 8'h23;
    end else begin
      if (io_wr && io_addr == 16'h23 && (m_idx == 8'h03 || m_regs[3] == 8'hC5)) begin
        if (m_idx == 8'h35) m_smi = (io_wdata[5] || io_wdata[4]);
        m_regs[m_idx] = io_wdata;
      end
      if (io_wr && io_addr == 16'h22) m_idx = io_wdata;
      if (pci_wr && pci_addr == 8'h07) m_status = m_status & ~(pci_wdata & 8'hFE);
    end
  end

  function automatic int exp_rdata();
    if (io_addr == 16'h22) return int'(m_idx);
    if (io_addr == 16'h23) return int'(m_regs[m_idx]);
    return 0;
  endfunction

  function automatic int mode_now();
    return int'(m_regs[8'h19][5:4]);
  endfunction

  function automatic bit exp_hit();
    int hb, sz, a;
    a = int'(host_addr);
    case (mode_now())
      1: begin hb = 'hA0000; sz = 'h20000; end
      2: begin hb = 'hE0000; sz = 'h10000; end
      3: begin hb = 'h30000; sz = 'h20000; end
      default: return 1'b0;
    endcase
    return host_strobe && a >= hb && a < hb + sz && (host_smm || m_regs[8'h19][3]);
  endfunction

  function automatic int exp_dram();
    if (!exp_hit()) return 0;
    if (mode_now() == 3) return int'(host_addr) - 'h30000 + 'hA0000;
    return int'(host_addr);
  endfunction

  function automatic string mode_tag();
    case (mode_now())
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(io_rdata == 8'(exp_rdata()), "R1 rdata", io_rdata, exp_rdata());
      check(hit == exp_hit(), {mode_tag(), " R8 hit"}, hit, exp_hit());
      check(int'(dram_addr) == exp_dram(), {mode_tag(), " R9 dram"}, dram_addr, exp_dram());
      check(smi_req == m_smi, "R10 smi", smi_req, m_smi);
      check(pci_status == m_status, "R11 status", pci_status, m_status);
    end
  end

  task automatic io_w(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic cfg_w(input logic [7:0] r, input logic [7:0] d);
    io_w(16'h22, r);
    io_w(16'h23, d);
  endtask

  task automatic pci_w(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    pci_wr = 1'b1; pci_addr = a; pci_wdata = d;
    @(posedge clk); #1;
    pci_wr = 1'b0;
  endtask

  task automatic probe(input int a);
    for (int s = 0; s < 2; s++) begin
      for (int st = 0; st < 2; st++) begin
        @(posedge clk); #1;
        host_addr = 20'(a); host_smm = s[0]; host_strobe = st[0];
      end
    end
  endtask

  task automatic sweep();
    int pts [12] = '{'h2FFFF, 'h30000, 'h4FFFF, 'h50000, 'h9FFFF, 'hA0000,
                     'hBFFFF, 'hC0000, 'hDFFFF, 'hE0000, 'hEFFFF, 'hF0000};
    for (int i = 0; i < 12; i++) probe(pts[i]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    io_addr = 16'h23;
    @(negedge clk);
    // R2 reset state
    check(io_rdata == 8'h00, "R2 reg0 after reset", io_rdata, 0);
    check(smi_req == 1'b0, "R2 smi after reset", smi_req, 0);
    check(pci_status == 8'h23, "R2 status after reset", pci_status, 'h23);
    io_addr = 16'h22;
    @(negedge clk);
    check(io_rdata == 8'h00, "R2 index after reset", io_rdata, 0);

    // R3 locked writes ignored
    cfg_w(8'h19, 8'h10);
    @(negedge clk);
    check(io_rdata == 8'h00, "R3 locked write ignored", io_rdata, 0);
    cfg_w(8'h35, 8'h30);
    @(negedge clk);
    check(smi_req == 1'b0, "R3 locked smi write ignored", smi_req, 0);
    io_w(16'h40, 8'h5A);
    sweep();

    // unlock and walk modes
    cfg_w(8'h03, 8'hC5);
    cfg_w(8'h19, 8'h10); sweep();
    cfg_w(8'h19, 8'h18); sweep();
    cfg_w(8'h19, 8'h20); sweep();
    cfg_w(8'h19, 8'h28); sweep();
    cfg_w(8'h19, 8'h30); sweep();
    cfg_w(8'h19, 8'h38); sweep();
    cfg_w(8'h19, 8'h08); sweep();

    // R10 SMI raise and clear
    cfg_w(8'h35, 8'h20);
    @(negedge clk);
    check(smi_req == 1'b1, "R10 smi raised by bit5", smi_req, 1);
    cfg_w(8'h35, 8'h10);
    cfg_w(8'h35, 8'h00);
    @(negedge clk);
    check(smi_req == 1'b0, "R10 smi cleared", smi_req, 0);
    cfg_w(8'h35, 8'h10);

    // relock, then R3 blocks further writes
    cfg_w(8'h03, 8'h00);
    cfg_w(8'h35, 8'h00);
    @(negedge clk);
    check(smi_req == 1'b1, "R3 locked clear ignored", smi_req, 1);
    cfg_w(8'h19, 8'h10);
    sweep();

    // R11 write-one-to-clear
    pci_w(8'h06, 8'hFF);
    @(negedge clk);
    check(pci_status == 8'h23, "R11 other offset ignored", pci_status, 'h23);
    pci_w(8'h07, 8'h02);
    @(negedge clk);
    check(pci_status == 8'h21, "R11 clear bit1", pci_status, 'h21);
    pci_w(8'h07, 8'hFF);
    @(negedge clk);
    check(pci_status == 8'h01, "R11 bit0 kept", pci_status, 'h01);

    repeat (4) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule